// File: doc/BRIEF.md
# Resource Tag Identifier Extractor

This block scans a byte image of configuration data, up to 128 bytes, that has been loaded into its local store. The image holds a chain of resource tags of two kinds. A short tag carries its length in its own first byte. A long tag carries a 16-bit little-endian length in the two bytes after it. One kind of long tag holds nested sub-fields of its own, and one sub-field inside it carries a 64-bit identifier. The block walks the chain once per start request. It reports the identifier and the byte offset at which the identifier begins, or an offset of zero when no identifier is present.

The image is written one byte per cycle through a plain write port. A single-cycle `start` pulse then launches the walk. The walker reads the store one byte per cycle and raises `done_o` when the walk is complete. `done_o`, `id_o` and `offset_o` then hold their values until the next accepted start.

Top module: `tag_id_walker`

## Requirements
- R1: After reset, `done_o` is 0, `id_o` is 0 and `offset_o` is 0.
- R2: A byte with bit 7 clear is a short tag. It occupies 1 + bits[2:0] bytes and its name is bits[6:3]. A short tag named 4'hF ends the walk, so tags placed after it are never examined.
- R3: A byte with bit 7 set is a long tag. Its name is bits[6:0]. It occupies 3 + L bytes, where L is the byte at +1 (low) and the byte at +2 (high). Only a long tag named 7'h0D is searched; every other long tag is skipped whole, whatever its contents.
- R4: If the byte at +3 of a 7'h0D tag equals 8'h3B, that tag is treated as 6 bytes long. Its contents are not searched, and the walk resumes 6 bytes after the tag byte.
- R5: Inside a 7'h0D tag, sub-fields start at +3. Each sub-field has a name in bits[5:0] of its first byte and a little-endian 16-bit length in its next two bytes. The scan advances by that length plus 3 and stops once it reaches the end of the enclosing tag.
- R6: A sub-field named 6'h3C supplies the 8 bytes after its 3-byte header as the identifier, first byte in `id_o[63:56]`. `offset_o` is the index of that first byte. When several such sub-fields are present, the last one scanned wins.
- R7: When no 6'h3C sub-field is scanned, `offset_o` is 0 and `id_o` is 0.
- R8: The walk ends when the tag index reaches 128 or more. Reads at indices of 128 and above return 8'h00, including identifier bytes that run past the image.
- R9: `done_o` rises in the cycle after the walk ends and stays high until the next start. A start accepted while the block is idle clears `done_o` at the next clock edge. A start that arrives during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| img_we | input | 1 | Write strobe for the image store |
| img_addr | input | 7 | Byte index written |
| img_data | input | 8 | Byte value written |
| start | input | 1 | One-cycle request to walk the stored image |
| id_o | output | 64 | Extracted identifier, first byte most significant |
| offset_o | output | 8 | Index of the first identifier byte, 0 when not found |
| done_o | output | 1 | Walk complete; results valid |

## Verification
The hardest outcome to reach from the ports is an identifier sub-field that lies in a well-formed searched tag but is reached only after other sub-fields of assorted lengths. Purely random bytes almost never form a consistent long tag, so the random images are built tag by tag. The generator writes short tags, skipped long tags and searched tags whose sub-field lists it assembles and whose lengths it computes, and it sometimes corrupts those lengths or inserts the escape byte. Directed images cover the remaining cases: an identifier that straddles index 127, a tag placed after the end marker, two identifiers in one tag, and an identifier hidden inside a skipped tag.

// File: rtl/tagwalk_pkg.sv
package tagwalk_pkg;

  typedef enum logic [3:0] {
    W_IDLE,
    W_TAG_A,
    W_TAG_D,
    W_LEN_LO,
    W_LEN_HI,
    W_CONT,
    W_SUB_A,
    W_SUB_N,
    W_SUB_L,
    W_SUB_H,
    W_ID,
    W_FIN
  } walk_st_t;

  localparam logic [3:0] SHORT_END_NAME = 4'hF;
  localparam logic [6:0] LONG_SEARCH    = 7'h0D;
  localparam logic [7:0] ESCAPE_BYTE    = 8'h3B;
  localparam logic [5:0] SUB_ID_NAME    = 6'h3C;
  localparam int unsigned ESCAPE_LEN    = 6;
  localparam int unsigned HDR_LEN       = 3;

endpackage

// File: rtl/tw_image_ram.sv
module tw_image_ram #(
  parameter int DEPTH = 128,
  parameter int IW    = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [7:0]               wdata,
  input  logic [IW-1:0]            raddr,
  output logic [7:0]               rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];
  logic [7:0] rd_q;
  logic       oob_q;

  // Plain synchronous write and registered read, suitable for block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) oob_q <= 1'b1;
    else     oob_q <= (raddr >= IW'(DEPTH));
  end

  assign rdata = oob_q ? 8'h00 : rd_q;

  // R8: an address past the image yields zero on the next cycle
  p_oob_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (raddr >= IW'(DEPTH)) |=> (rdata == 8'h00));

endmodule

// File: rtl/tw_id_shift.sv
module tw_id_shift #(
  parameter int ID_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  shift_en,
  input  logic [7:0]            din,
  output logic [8*ID_BYTES-1:0] id_q
);
  localparam int IDW = 8 * ID_BYTES;

  // Earlier bytes move towards the top, so the first byte ends in the MSBs.
  always_ff @(posedge clk) begin
    if (rst || clear) id_q <= '0;
    else if (shift_en) id_q <= {id_q[IDW-9:0], din};
  end

  // R7: a fresh walk starts from an all-zero identifier
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (clear && !shift_en) |=> (id_q == '0));

endmodule

// File: rtl/tw_walker.sv
module tw_walker
  import tagwalk_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int ID_BYTES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [7:0]               rd_data,
  output logic [$clog2(DEPTH)+10:0] rd_addr,
  output logic                     shift_en,
  output logic                     id_clear,
  output logic [$clog2(DEPTH):0]   offset_o,
  output logic                     done_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = AW + 11;
  localparam int OW = AW + 1;
  localparam int KW = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

  walk_st_t      st_q;
  logic [IW-1:0] i_q, j_q, end_q, sub_adv_q;
  logic [6:0]    name_q;
  logic [5:0]    sub_name_q;
  logic [7:0]    lo_q;
  logic [KW-1:0] k_q;
  logic [IW-1:0] len16;

  assign len16    = IW'({rd_data, lo_q}) + IW'(HDR_LEN);
  assign id_clear = (st_q == W_IDLE) && start;
  assign shift_en = (st_q == W_ID);

  // Address for the byte that arrives in the following state.
  always_comb begin
    unique case (st_q)
      W_TAG_D:  rd_addr = i_q + IW'(1);
      W_LEN_LO: rd_addr = i_q + IW'(2);
      W_LEN_HI: rd_addr = i_q + IW'(3);
      W_SUB_A:  rd_addr = j_q;
      W_SUB_N:  rd_addr = j_q + IW'(1);
      W_SUB_L:  rd_addr = j_q + IW'(2);
      W_SUB_H:  rd_addr = j_q + IW'(3);
      W_ID:     rd_addr = j_q + IW'(4) + IW'(k_q);
      default:  rd_addr = i_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= W_IDLE;
      i_q        <= '0;
      j_q        <= '0;
      end_q      <= '0;
      sub_adv_q  <= '0;
      name_q     <= '0;
      sub_name_q <= '0;
      lo_q       <= '0;
      k_q        <= '0;
      offset_o   <= '0;
      done_o     <= 1'b0;
    end else begin
      unique case (st_q)
        W_IDLE: if (start) begin
          i_q      <= '0;
          offset_o <= '0;
          done_o   <= 1'b0;
          st_q     <= W_TAG_A;
        end
        W_TAG_A: st_q <= (i_q >= IW'(DEPTH)) ? W_FIN : W_TAG_D;
        W_TAG_D: begin
          if (!rd_data[7]) begin
            i_q  <= i_q + IW'(rd_data[2:0]) + IW'(1);
            st_q <= (rd_data[6:3] == SHORT_END_NAME) ? W_FIN : W_TAG_A;
          end else begin
            name_q <= rd_data[6:0];
            st_q   <= W_LEN_LO;
          end
        end
        W_LEN_LO: begin
          lo_q <= rd_data;
          st_q <= W_LEN_HI;
        end
        W_LEN_HI: begin
          if (name_q == LONG_SEARCH) begin
            end_q <= i_q + len16;
            st_q  <= W_CONT;
          end else begin
            i_q  <= i_q + len16;
            st_q <= W_TAG_A;
          end
        end
        W_CONT: begin
          if (rd_data == ESCAPE_BYTE) begin
            i_q  <= i_q + IW'(ESCAPE_LEN);
            st_q <= W_TAG_A;
          end else begin
            j_q  <= i_q + IW'(HDR_LEN);
            st_q <= W_SUB_A;
          end
        end
        W_SUB_A: begin
          // Past the image every byte reads zero and cannot match, so jump.
          if (j_q >= end_q || j_q >= IW'(DEPTH)) begin
            i_q  <= end_q;
            st_q <= W_TAG_A;
          end else begin
            st_q <= W_SUB_N;
          end
        end
        W_SUB_N: begin
          sub_name_q <= rd_data[5:0];
          st_q       <= W_SUB_L;
        end
        W_SUB_L: begin
          lo_q <= rd_data;
          st_q <= W_SUB_H;
        end
        W_SUB_H: begin
          sub_adv_q <= len16;
          if (sub_name_q == SUB_ID_NAME) begin
            offset_o <= OW'(j_q + IW'(HDR_LEN));
            k_q      <= '0;
            st_q     <= W_ID;
          end else begin
            j_q  <= j_q + len16;
            st_q <= W_SUB_A;
          end
        end
        W_ID: begin
          if (k_q == KW'(ID_BYTES - 1)) begin
            j_q  <= j_q + sub_adv_q;
            st_q <= W_SUB_A;
          end else begin
            k_q <= k_q + KW'(1);
          end
        end
        W_FIN: begin
          done_o <= 1'b1;
          st_q   <= W_IDLE;
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  // R9: results stay valid until a new start
  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start) |=> done_o);
  // R9: an accepted start withdraws done at once
  p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == W_IDLE && start) |=> !done_o);
  // R6: an identifier can never begin before index 6
  p_ofs_min_r6: assert property (@(posedge clk) disable iff (rst)
    (offset_o != '0) |-> (offset_o >= OW'(6)));
  // R5: a sub-field is only decoded inside its enclosing tag
  p_sub_inside_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == W_SUB_N) |-> (j_q < end_q));

endmodule

// File: rtl/tag_id_walker.sv
module tag_id_walker #(
  parameter int DEPTH    = 128,
  parameter int ID_BYTES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     img_we,
  input  logic [$clog2(DEPTH)-1:0] img_addr,
  input  logic [7:0]               img_data,
  input  logic                     start,
  output logic [8*ID_BYTES-1:0]    id_o,
  output logic [$clog2(DEPTH):0]   offset_o,
  output logic                     done_o
);
  localparam int IW = $clog2(DEPTH) + 11;

  logic [IW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          shift_en;
  logic          id_clear;

  tw_image_ram #(.DEPTH(DEPTH), .IW(IW)) ram_i (
    .clk   (clk),
    .rst   (rst),
    .we    (img_we),
    .waddr (img_addr),
    .wdata (img_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  tw_walker #(.DEPTH(DEPTH), .ID_BYTES(ID_BYTES)) walk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .shift_en (shift_en),
    .id_clear (id_clear),
    .offset_o (offset_o),
    .done_o   (done_o)
  );

  tw_id_shift #(.ID_BYTES(ID_BYTES)) id_i (
    .clk      (clk),
    .rst      (rst),
    .clear    (id_clear),
    .shift_en (shift_en),
    .din      (rd_data),
    .id_q     (id_o)
  );

endmodule

// File: tb/tag_id_walker_tb.sv
module tag_id_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        img_we = 1'b0;
  logic [6:0]  img_addr = '0;
  logic [7:0]  img_data = '0;
  logic        start = 1'b0;
  logic [63:0] id_o;
  logic [7:0]  offset_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] img [128];

  always #2 clk = ~clk;  // 250 MHz

  tag_id_walker dut_i (
    .clk(clk), .rst(rst), .img_we(img_we), .img_addr(img_addr),
    .img_data(img_data), .start(start), .id_o(id_o),
    .offset_o(offset_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int rd(int a);
    return (a >= 0 && a < 128) ? int'(img[a]) : 0;
  endfunction

  // Expected results from the tag rules alone.
  function automatic void model(output logic [63:0] eid, output int eofs);
    int i = 0;
    bit fin = 0;
    eid = '0;
    eofs = 0;
    while (i < 128 && !fin) begin
      int z = rd(i);
      int len;
      if (z < 128) begin
        len = 1 + (z & 7);
        if (((z >> 3) & 15) == 15) fin = 1;
      end else begin
        len = 3 + rd(i + 1) + (rd(i + 2) << 8);
        if ((z & 127) == 13) begin
          int j = i + 3;
          if (rd(j) == 8'h3B) len = 6;
          else begin
            while (j < i + len) begin
              int sl = rd(j + 1) + (rd(j + 2) << 8);
              if ((rd(j) & 63) == 60) begin
                eofs = j + 3;
                for (int b = 0; b < 8; b++) eid[63-8*b -: 8] = 8'(rd(j + 3 + b));
              end
              j += sl + 3;
            end
          end
        end
      end
      i += len;
    end
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_img();
    for (int a = 0; a < 128; a++) begin
      @(negedge clk);
      img_we = 1'b1; img_addr = 7'(a); img_data = img[a];
    end
    @(negedge clk);
    img_we = 1'b0;
  endtask

  task automatic run_case(string req);
    logic [63:0] eid;
    int eofs;
    int n = 0;
    load_img();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9", "done after start", 64'(done_o), 64'd0);
    while (!done_o && n < 5000) begin @(negedge clk); n++; end
    model(eid, eofs);
    check(req, "done", 64'(done_o), 64'd1);
    check((eofs != 0) ? "R6" : "R7", "offset", 64'(offset_o), 64'(eofs));
    check((eofs != 0) ? "R6" : "R7", "id", id_o, eid);
    repeat (3) @(negedge clk);
    check("R9", "done held", 64'(done_o), 64'd1);
  endtask

  function automatic void put(int p, int v);
    if (p >= 0 && p < 128) img[p] = 8'(v);
  endfunction

  task automatic gen_random();
    int pos = 0;
    for (int a = 0; a < 128; a++) img[a] = 8'($urandom);
    while (pos < 128) begin
      int r = $urandom % 10;
      if (r < 3) begin
        int l = $urandom % 8;
        put(pos, ((($urandom % 15) & 15) << 3) | l);
        pos += 1 + l;
      end else if (r == 3) begin
        put(pos, 8'h78 | ($urandom % 8));
        pos = 128;
      end else if (r < 6) begin
        int l = $urandom % 7;
        int nm = $urandom % 127;
        if (nm == 13) nm = 14;
        put(pos, 128 | nm); put(pos + 1, l); put(pos + 2, 0);
        pos += 3 + l;
      end else begin
        int p0 = pos;
        int q = pos + 3;
        int tot;
        put(p0, 8'h8D);
        if ($urandom % 6 == 0) put(q, 8'h3B);
        else begin
          int ns = 1 + $urandom % 3;
          for (int s = 0; s < ns; s++) begin
            if ($urandom % 2 == 0) begin
              put(q, 60 | (($urandom % 4) << 6)); put(q + 1, 8); put(q + 2, 0);
              q += 11;
            end else begin
              int l = $urandom % 5;
              int nm = $urandom % 64;
              if (nm == 60) nm = 61;
              put(q, nm); put(q + 1, l); put(q + 2, 0);
              q += 3 + l;
            end
          end
        end
        tot = q - p0 - 3;
        if ($urandom % 5 == 0) tot = tot + int'($urandom % 7) - 3;
        if (tot < 0) tot = 0;
        put(p0 + 1, tot); put(p0 + 2, 0);
        pos = p0 + 3 + tot;
      end
    end
  endtask

  task automatic clear_img();
    for (int a = 0; a < 128; a++) img[a] = 8'h00;
  endtask

  // Searched tag at p with one identifier sub-field; returns the next index.
  function automatic int put_id_tag(int p, logic [63:0] v);
    put(p, 8'h8D); put(p + 1, 11); put(p + 2, 0);
    put(p + 3, 8'h3C); put(p + 4, 8); put(p + 5, 0);
    for (int b = 0; b < 8; b++) put(p + 6 + b, int'(v[63-8*b -: 8]));
    return p + 14;
  endfunction

  initial begin
    int p;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "done", 64'(done_o), 64'd0);
    check("R1", "id", id_o, 64'd0);
    check("R1", "offset", 64'(offset_o), 64'd0);

    // R8: all zero image, 128 one-byte short tags, nothing found
    clear_img();
    run_case("R8");

    // R6: identifier at the very start, then an end tag
    clear_img();
    p = put_id_tag(0, 64'h1122334455667788);
    put(p, 8'h78);
    run_case("R6");
    check("R6", "direct offset", 64'(offset_o), 64'd6);
    check("R6", "direct id", id_o, 64'h1122334455667788);

    // R2: short tags, end tag, then a searched tag that must be ignored
    clear_img();
    put(0, 8'h12); put(3, 8'h7B); put(7, 8'h01);
    put(9, 8'h7E);
    void'(put_id_tag(16, 64'hDEADBEEF00C0FFEE));
    run_case("R2");
    check("R2", "after end offset", 64'(offset_o), 64'd0);

    // R4: escape byte makes the tag 6 long; the tag at 6 is searched
    clear_img();
    put(0, 8'h8D); put(1, 40); put(2, 0); put(3, 8'h3B);
    void'(put_id_tag(6, 64'hA5A5_0102_0304_5A5A));
    run_case("R4");
    check("R4", "escape offset", 64'(offset_o), 64'd12);

    // R3: skipped long tag holding a fake identifier, then the real one
    clear_img();
    put(0, 8'h82); put(1, 11); put(2, 0);
    put(3, 8'h3C); put(4, 8); put(5, 0);
    for (int b = 0; b < 8; b++) put(6 + b, 8'hEE);
    void'(put_id_tag(14, 64'h0807060504030201));
    run_case("R3");
    check("R3", "skip offset", 64'(offset_o), 64'd20);

    // R6: two identifiers in one tag after an unrelated sub-field; last wins
    clear_img();
    put(0, 8'h8D); put(1, 27); put(2, 0);
    put(3, 8'h05); put(4, 2); put(5, 0);
    put(8, 8'hFC); put(9, 8); put(10, 0);
    for (int b = 0; b < 8; b++) put(11 + b, 8'h10 + b);
    put(19, 8'h3C); put(20, 8); put(21, 0);
    for (int b = 0; b < 8; b++) put(22 + b, 8'h90 + b);
    put(30, 8'h7F);
    run_case("R6");
    check("R6", "last offset", 64'(offset_o), 64'd22);

    // R5: identifier sub-field lies past the end of its tag
    clear_img();
    put(0, 8'h8D); put(1, 5); put(2, 0);
    put(3, 8'h01); put(4, 2); put(5, 0);
    put(8, 8'h3C); put(9, 8); put(10, 0);
    run_case("R5");
    check("R5", "outside offset", 64'(offset_o), 64'd0);

    // R8: identifier straddles index 127; missing bytes read zero
    clear_img();
    put(0, 8'h81); put(1, 115); put(2, 0);
    for (int a = 118; a < 128; a++) put(a, 0);
    void'(put_id_tag(118, 64'hC1C2C3C4C5C6C7C8));
    run_case("R8");
    check("R8", "edge id", id_o, 64'hC1C2C3C4_00000000);
    check("R8", "edge offset", 64'(offset_o), 64'd124);

    // R5 R6 R7: tag-built random images
    for (int t = 0; t < 40; t++) begin
      gen_random();
      run_case("R5");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule